// File: doc/BRIEF.md
# System Control and Memory Window Register

This block holds the control state a host processor uses to restart itself, to switch the address range seen by both the processor and the DMA engine, and to move one 64 KB region of the memory map from RAM to a sub-system port. The host reaches it over an 8-bit I/O bus with a 16-bit port address, a write strobe and a read strobe. Two port addresses are decoded, and every other port reads back as all ones.

The processor-control port starts a one-cycle processor reset when it is written with a particular code in its two top data bits. The same write also sets a sticky flag that records the restart. Bit 0 of every write to that port picks a 20-bit or a 24-bit address mask. A shutdown-event input sets a second sticky flag. Reading the port returns both flags and then clears them, but an event that arrives in the same cycle as the clearing read is kept. The window port is a plain byte. Its bit 7 steers the 0xC0000-0xCFFFF memory region to the sub-system, and its bit 1 drives an indicator LED.

Top module: `sysctl_win`

## Requirements
- R1: A write to port 0x0060 whose data bits [7:6] are 2'b01 drives `cpu_rst_pulse` high for exactly the one cycle after the write cycle and sets the restart flag. Writes with bits [7:6] equal to 2'b00, 2'b10 or 2'b11 give no pulse.
- R2: Data bit 0 of every write to port 0x0060 selects the address mask from the next cycle on: 1 gives 0xFFFFFF and 0 gives 0x0FFFFF. `cpu_addr_mask` and `dma_addr_mask` are always equal.
- R3: While `rst` is high at a clock edge, the mask returns to 0x0FFFFF, both flags clear, the window byte becomes 0x00 and `cpu_rst_pulse` is low.
- R4: A read of port 0x0060 returns the restart flag in bit 0 and the shutdown flag in bit 1, with bits [7:2] zero. The read clears both flags at the end of the read cycle.
- R5: A high `cpu_shutdown` sets the sticky shutdown flag. If a shutdown event, or a restart write as in R1, occurs in the same cycle as a clearing read, the affected flag stays set.
- R6: Port 0xFD0F is a read/write byte. A read returns the last value written, or 0x00 after reset.
- R7: `win_sub_sel` is high exactly when bit 7 of the window byte is 1 and `mem_addr[19:16]` equals 4'hC. It changes in the same cycle as `mem_addr`.
- R8: `led_ins` follows bit 1 of the window byte.
- R9: A read of any port other than 0x0060 and 0xFD0F returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe, one cycle per read; clears the flags of port 0x0060 |
| io_rdata | output | 8 | Read data, decoded from io_addr without a register |
| cpu_shutdown | input | 1 | Processor shutdown event |
| mem_addr | input | 20 | Current memory address for the window decode |
| cpu_rst_pulse | output | 1 | One-cycle processor reset |
| cpu_addr_mask | output | 24 | Address mask to the processor |
| dma_addr_mask | output | 24 | Address mask to the DMA engine |
| win_sub_sel | output | 1 | High when the current memory access goes to the sub-system |
| led_ins | output | 1 | Insert indicator LED |

## Verification
On every cycle, the assertions check these rules: a reset code leads to a pulse and a set flag, every pulse can be traced back to a reset-code write, the two masks match and take one of only two values, a shutdown event always leaves the flag set, a read with no new event leaves it clear, and the window select is only active inside the window region. The bench scenarios cover the things that need a sequence of bus operations. These are the read-back values and clear-on-read order of the flags, the same-cycle conflict between read and event, the rejection of the three other code patterns, the window-byte readback, the edges of the window region, the all-ones result for undecoded ports, and a reset in the middle of a run.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
    localparam int DATA_W = 8;
    localparam int MASK_W = 24;
    localparam logic [1:0] RST_CODE = 2'b01;
    localparam logic [DATA_W-1:0] IDLE_READ = '1;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic [DATA_W-1:0] data;
    } port_req_t;

    typedef struct packed {
        logic sd;
        logic rs;
    } cpu_flags_t;

    function automatic logic [MASK_W-1:0] mask_sel(input logic wide, input int narrow_bits);
        logic [MASK_W-1:0] narrow;
        narrow = MASK_W'((64'd1 << narrow_bits) - 64'd1);
        return wide ? {MASK_W{1'b1}} : narrow;
    endfunction
endpackage

// File: rtl/sysctl_cpu_ctl.sv
module sysctl_cpu_ctl
    import sysctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  port_req_t  req,
    input  logic       shutdown_evt,
    output cpu_flags_t flags,
    output logic       reset_pulse,
    output logic       mask_wide
);
    logic trig;
    assign trig = req.wr && (req.data[DATA_W-1 -: 2] == RST_CODE);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags       <= '0;
            reset_pulse <= 1'b0;
            mask_wide   <= 1'b0;
        end else begin
            reset_pulse <= trig;
            if (req.wr) mask_wide <= req.data[0];
            flags.rs <= trig | (flags.rs & ~req.rd);
            flags.sd <= shutdown_evt | (flags.sd & ~req.rd);
        end
    end

    // R1
    rst_code_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        trig |=> (reset_pulse && flags.rs));
    // R1
    pulse_origin_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(reset_pulse) |-> $past(req.wr));
    // R5
    shutdown_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        shutdown_evt |=> flags.sd);
    // R4
    read_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (req.rd && !shutdown_evt) |=> !flags.sd);
endmodule

// File: rtl/sysctl_win_reg.sv
module sysctl_win_reg
    import sysctl_pkg::*;
#(
    parameter int          MEM_AW  = 20,
    parameter int          TAG_W   = 4,
    parameter logic [3:0]  WIN_TAG = 4'hC,
    parameter int          SEL_BIT = 7,
    parameter int          LED_BIT = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  port_req_t         req,
    input  logic [MEM_AW-1:0] mem_addr,
    output logic [DATA_W-1:0] ctrl,
    output logic              win_sel,
    output logic              led
);
    logic tag_hit;

    always_ff @(posedge clk) begin
        if (rst) ctrl <= '0;
        else if (req.wr) ctrl <= req.data;
    end

    assign tag_hit = (mem_addr[MEM_AW-1 -: TAG_W] == WIN_TAG[TAG_W-1:0]);
    assign win_sel = ctrl[SEL_BIT] && tag_hit;
    assign led     = ctrl[LED_BIT];

    // R7
    win_region_chk: assert property (@(posedge clk) disable iff (rst)
        win_sel |-> (mem_addr[MEM_AW-1 -: TAG_W] == WIN_TAG[TAG_W-1:0]));
endmodule

// File: rtl/sysctl_win.sv
module sysctl_win
    import sysctl_pkg::*;
#(
    parameter int          IO_AW       = 16,
    parameter int          MEM_AW      = 20,
    parameter int          NARROW_BITS = 20,
    parameter logic [15:0] CPU_PORT    = 16'h0060,
    parameter logic [15:0] WIN_PORT    = 16'hFD0F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IO_AW-1:0]  io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    input  logic              io_wr,
    input  logic              io_rd,
    output logic [DATA_W-1:0] io_rdata,
    input  logic              cpu_shutdown,
    input  logic [MEM_AW-1:0] mem_addr,
    output logic              cpu_rst_pulse,
    output logic [MASK_W-1:0] cpu_addr_mask,
    output logic [MASK_W-1:0] dma_addr_mask,
    output logic              win_sub_sel,
    output logic              led_ins
);
    logic       hit_cpu, hit_win, mask_wide;
    port_req_t  req_cpu, req_win;
    cpu_flags_t flags;
    logic [DATA_W-1:0] win_byte;

    assign hit_cpu = (io_addr == CPU_PORT[IO_AW-1:0]);
    assign hit_win = (io_addr == WIN_PORT[IO_AW-1:0]);

    assign req_cpu = '{wr: io_wr && hit_cpu, rd: io_rd && hit_cpu, data: io_wdata};
    assign req_win = '{wr: io_wr && hit_win, rd: io_rd && hit_win, data: io_wdata};

    sysctl_cpu_ctl u_cpu (
        .clk(clk), .rst(rst), .req(req_cpu), .shutdown_evt(cpu_shutdown),
        .flags(flags), .reset_pulse(cpu_rst_pulse), .mask_wide(mask_wide)
    );

    sysctl_win_reg #(.MEM_AW(MEM_AW)) u_win (
        .clk(clk), .rst(rst), .req(req_win), .mem_addr(mem_addr),
        .ctrl(win_byte), .win_sel(win_sub_sel), .led(led_ins)
    );

    always_comb begin
        if (hit_cpu)      io_rdata = {{(DATA_W-2){1'b0}}, flags.sd, flags.rs};
        else if (hit_win) io_rdata = win_byte;
        else              io_rdata = IDLE_READ;
    end

    assign cpu_addr_mask = mask_sel(mask_wide, NARROW_BITS);
    assign dma_addr_mask = cpu_addr_mask;

    // R2
    mask_shape_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr_mask == dma_addr_mask) &&
        (cpu_addr_mask == 24'hFFFFFF || cpu_addr_mask == 24'h0FFFFF));
endmodule

// File: tb/tb_sysctl_win.sv
module tb_sysctl_win;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic io_wr = 1'b0, io_rd = 1'b0, cpu_shutdown = 1'b0;
    logic [19:0] mem_addr = '0;
    logic [7:0]  io_rdata;
    logic cpu_rst_pulse, win_sub_sel, led_ins;
    logic [23:0] cpu_addr_mask, dma_addr_mask;
    int total = 0, bad = 0;

    always #5 clk = ~clk;

    sysctl_win dut (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata),
        .cpu_shutdown(cpu_shutdown), .mem_addr(mem_addr),
        .cpu_rst_pulse(cpu_rst_pulse), .cpu_addr_mask(cpu_addr_mask),
        .dma_addr_mask(dma_addr_mask), .win_sub_sel(win_sub_sel), .led_ins(led_ins)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1 d = io_rdata;
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    task automatic t_reset_state();
        logic [7:0] d;
        do_reset();
        chk("R3 mask", cpu_addr_mask, 24'h0FFFFF);
        chk("R3 pulse", cpu_rst_pulse, 0);
        bus_read(16'h0060, d); chk("R3 flags", d, 8'h00);
        bus_read(16'hFD0F, d); chk("R3 window byte", d, 8'h00);
        mem_addr = 20'hC0000; #1 chk("R7 window off after reset", win_sub_sel, 0);
        chk("R8 led after reset", led_ins, 0);
    endtask

    task automatic t_restart();
        logic [7:0] d;
        bus_write(16'h0060, 8'h41);
        chk("R1 pulse high", cpu_rst_pulse, 1);
        chk("R2 wide mask cpu", cpu_addr_mask, 24'hFFFFFF);
        chk("R2 wide mask dma", dma_addr_mask, 24'hFFFFFF);
        @(negedge clk); chk("R1 pulse one cycle", cpu_rst_pulse, 0);
        bus_read(16'h0060, d); chk("R4 restart flag read", d, 8'h01);
        bus_read(16'h0060, d); chk("R4 cleared by read", d, 8'h00);
    endtask

    task automatic t_other_codes();
        logic [7:0] d;
        logic [7:0] codes [3] = '{8'h80, 8'hC1, 8'h00};
        foreach (codes[i]) begin
            bus_write(16'h0060, codes[i]);
            chk("R1 no pulse other code", cpu_rst_pulse, 0);
            chk("R2 mask from bit0", cpu_addr_mask, codes[i][0] ? 24'hFFFFFF : 24'h0FFFFF);
        end
        bus_read(16'h0060, d); chk("R1 no flag other code", d, 8'h00);
        bus_write(16'hFD0F, 8'h01);
        chk("R2 other port leaves mask", cpu_addr_mask, 24'h0FFFFF);
    endtask

    task automatic t_shutdown();
        logic [7:0] d;
        @(negedge clk); cpu_shutdown = 1'b1;
        @(negedge clk); cpu_shutdown = 1'b0;
        bus_read(16'h0060, d); chk("R5 shutdown flag", d, 8'h02);
        bus_read(16'h0060, d); chk("R4 shutdown cleared", d, 8'h00);
        // same-cycle event and read: event wins
        @(negedge clk);
        io_addr = 16'h0060; io_rd = 1'b1; cpu_shutdown = 1'b1;
        #1 chk("R5 read before event", io_rdata, 8'h00);
        @(negedge clk); io_rd = 1'b0; cpu_shutdown = 1'b0;
        bus_read(16'h0060, d); chk("R5 event kept over read", d, 8'h02);
        // restart write and read in the same cycle
        @(negedge clk);
        io_addr = 16'h0060; io_wdata = 8'h40; io_wr = 1'b1; io_rd = 1'b1;
        @(negedge clk); io_wr = 1'b0; io_rd = 1'b0;
        bus_read(16'h0060, d); chk("R5 restart kept over read", d, 8'h01);
    endtask

    task automatic t_window();
        logic [7:0] d;
        bus_write(16'hFD0F, 8'h82);
        bus_read(16'hFD0F, d); chk("R6 readback", d, 8'h82);
        chk("R8 led on", led_ins, 1);
        mem_addr = 20'hC0000; #1 chk("R7 low edge", win_sub_sel, 1);
        mem_addr = 20'hCFFFF; #1 chk("R7 high edge", win_sub_sel, 1);
        mem_addr = 20'hBFFFF; #1 chk("R7 below", win_sub_sel, 0);
        mem_addr = 20'hD0000; #1 chk("R7 above", win_sub_sel, 0);
        bus_write(16'hFD0F, 8'h5D);
        bus_read(16'hFD0F, d); chk("R6 readback 2", d, 8'h5D);
        chk("R8 led off", led_ins, 0);
        mem_addr = 20'hC1234; #1 chk("R7 bit7 clear", win_sub_sel, 0);
    endtask

    task automatic t_undecoded();
        logic [7:0] d;
        bus_read(16'h0061, d); chk("R9 port 0061", d, 8'hFF);
        bus_read(16'hFD0E, d); chk("R9 port FD0E", d, 8'hFF);
        bus_read(16'h0000, d); chk("R9 port 0000", d, 8'hFF);
    endtask

    task automatic t_midrun_reset();
        logic [7:0] d;
        bus_write(16'h0060, 8'h41);
        bus_write(16'hFD0F, 8'hFF);
        do_reset();
        chk("R3 mask after reset", cpu_addr_mask, 24'h0FFFFF);
        bus_read(16'h0060, d); chk("R3 flags after reset", d, 8'h00);
        bus_read(16'hFD0F, d); chk("R3 window after reset", d, 8'h00);
    endtask

    initial begin
        fork
            begin
                t_reset_state();
                t_restart();
                t_other_codes();
                t_shutdown();
                t_window();
                t_undecoded();
                t_midrun_reset();
            end
            begin
                repeat (20000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule